// File: doc/BRIEF.md
# Endpoint Bank Status Tracker

This block follows the state of a single device-side USB endpoint that owns one or two packet buffer banks. It takes single-cycle event strobes from the packet engine: an OUT packet landing in a bank, the CPU filling an IN bank, the CPU releasing an OUT bank, an IN packet sent, a host handshake, an IN token, and endpoint allocation. From these it keeps an 8-bit status word and an interrupt request. The FIFO memory, the serial engine and CRC logic sit elsewhere.

When the endpoint is allocated, the block checks the requested packet size and bank count against the FIFO capacity and the bank limit. It then empties every bank and sets the toggle back to DATA0. After that it counts occupied banks. On isochronous traffic it flags data that arrives with no free bank, and IN tokens that find no filled bank. It also reports the data toggle in a way that depends on direction. On an OUT endpoint it shows the PID stored with the bank the CPU reads next. On an IN endpoint it shows the PID of the next packet to transmit. Software clears the two error flags through a write strobe.

Top module: `ep_bank_status`

## Requirements
- R1: A synchronous active-high `rst` clears every status bit and `irq` at the clock edge.
- R2: On `alloc_stb` the config-ok bit (status[7]) becomes 1 exactly when 1 <= `cfg_bank_cnt` <= 2 and (8 << `cfg_size_code`) * `cfg_bank_cnt` <= 256 bytes, and becomes 0 otherwise. The same edge empties all banks and sets the toggle to DATA0. A failed check leaves zero usable banks. Data events in the allocation cycle are ignored.
- R3: The config-ok bit keeps its value in every cycle without `alloc_stb`.
- R4: The overflow flag (status[6]) is set when an isochronous OUT endpoint sees `rx_pkt_stb` while every usable bank is occupied.
- R5: The underflow flag (status[5]) is set when an isochronous IN endpoint sees `in_token_stb` while no bank is filled.
- R6: With `sw_wr_stb` high, a 0 in `sw_wr_data[6]` or `sw_wr_data[5]` clears that flag. A 1 leaves it unchanged, and all other data bits have no effect.
- R7: If a hardware set and a software clear of a flag fall in the same cycle, the flag ends up set.
- R8: The toggle field (status[3:2]) reads 00 for DATA0 and 01 for DATA1 and never has bit 3 set. On an OUT endpoint it shows `rx_pid_data1` as stored with the oldest unreleased bank (the next bank to be read).
- R9: On an IN endpoint the toggle field flips each time a filled bank is freed. Non-isochronous endpoints free a bank on `tx_ack_stb`, isochronous endpoints on `tx_sent_stb`; `tx_sent_stb` alone does nothing on a non-isochronous endpoint.
- R10: The busy field (status[1:0]) goes up on a fill (`rx_pkt_stb` for OUT, `cpu_fill_stb` for IN) when a usable bank is free, and goes down on a release when it is nonzero. Fills when full and releases when empty are ignored. Both are judged against the count before the edge.
- R11: Status bit 4 always reads 0.
- R12: `irq` is high when (overflow and `ovf_irq_en`) or (underflow and `unf_irq_en`), with the enables sampled at the same edge as the flags.
- R13: `status` and `irq` are registers. An event strobed in one cycle shows at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_dir_in | input | 1 | 1 for an IN endpoint, 0 for OUT; changed only with allocation |
| ep_iso | input | 1 | 1 for isochronous transfer type; changed only with allocation |
| alloc_stb | input | 1 | Allocate the endpoint and check its configuration |
| cfg_size_code | input | 3 | Packet size code, size = 8 << code bytes |
| cfg_bank_cnt | input | 2 | Requested number of banks |
| rx_pkt_stb | input | 1 | OUT packet received into a bank |
| rx_pid_data1 | input | 1 | PID of the received packet, 1 for DATA1 |
| cpu_fill_stb | input | 1 | CPU has filled an IN bank |
| bank_release_stb | input | 1 | CPU has released an OUT bank |
| in_token_stb | input | 1 | IN token arrived |
| tx_sent_stb | input | 1 | IN packet transmitted |
| tx_ack_stb | input | 1 | Host acknowledged the IN packet |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| unf_irq_en | input | 1 | Underflow interrupt enable |
| sw_wr_stb | input | 1 | Software write to the status word |
| sw_wr_data | input | 8 | Software write data |
| status | output | 8 | Status word: config-ok, overflow, underflow, reserved, toggle, busy |
| irq | output | 1 | Endpoint interrupt request |

## Verification
A wrong bank count or a misplaced ring pointer shows up in the busy field at the next edge. It then spreads: fills get refused, overflow or underflow flags appear where none should, and on OUT endpoints the displayed toggle comes from the wrong bank. A stale IN toggle stays hidden until a bank is freed. At that point the field disagrees with the expected flip count, and it keeps disagreeing until the next allocation. The flags are sticky, so one spurious set stays visible on `status` and `irq` until software clears it.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;
  localparam int STAT_W  = 8;
  localparam int CNT_W   = 2;
  localparam int BIT_OVF = 6;
  localparam int BIT_UNF = 5;
  localparam int FLAG_N  = 2;

  typedef struct packed {
    logic             cfg_ok;
    logic             ovf;
    logic             unf;
    logic             resv;
    logic [1:0]       tog;
    logic [CNT_W-1:0] busy;
  } ep_stat_t;
endpackage

// File: rtl/ep_cfg_check.sv
module ep_cfg_check #(
  parameter int SIZE_W     = 3,
  parameter int CNT_W      = 2,
  parameter int MIN_BYTES  = 8,
  parameter int FIFO_BYTES = 256,
  parameter int NBANK_MAX  = 2
) (
  input  logic [SIZE_W-1:0] size_code,
  input  logic [CNT_W-1:0]  bank_cnt,
  output logic              cfg_ok
);
  int unsigned need_bytes;

  always_comb begin
    need_bytes = (32'(MIN_BYTES) << size_code) * 32'(bank_cnt);
    cfg_ok = (bank_cnt != '0) && (32'(bank_cnt) <= 32'(NBANK_MAX)) &&
             (need_bytes <= 32'(FIFO_BYTES));
  end
endmodule

// File: rtl/ep_sticky_flag.sv
module ep_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q,
  output logic q_nxt
);
  // hardware set dominates a same-cycle software clear
  assign q_nxt = hw_set | (q & ~sw_clr);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/ep_bank_ring.sv
module ep_bank_ring #(
  parameter int NBANK_MAX = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] nb,
  input  logic             push,
  input  logic             pop,
  input  logic             push_pid,
  output logic [CNT_W-1:0] busy_q,
  output logic [CNT_W-1:0] busy_nxt,
  output logic             head_pid_nxt
);
  localparam int PTR_W = (NBANK_MAX > 1) ? $clog2(NBANK_MAX) : 1;

  logic [PTR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic             pid_mem [NBANK_MAX];

  function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                 input logic [CNT_W-1:0] n);
    int unsigned nxt;
    nxt = 32'(p) + 32'd1;
    if (nxt >= 32'(n)) return '0;
    return PTR_W'(nxt);
  endfunction

  always_comb begin
    if (clear) begin
      busy_nxt = '0;
      wr_nxt   = '0;
      rd_nxt   = '0;
    end else begin
      busy_nxt = busy_q + CNT_W'(push) - CNT_W'(pop);
      wr_nxt   = push ? ring_step(wr_q, nb) : wr_q;
      rd_nxt   = pop  ? ring_step(rd_q, nb) : rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_nxt;
      wr_q   <= wr_nxt;
      rd_q   <= rd_nxt;
    end
  end

  for (genvar gi = 0; gi < NBANK_MAX; gi++) begin : g_pid
    always_ff @(posedge clk) begin
      if (rst || clear)                          pid_mem[gi] <= 1'b0;
      else if (push && wr_q == PTR_W'(gi))       pid_mem[gi] <= push_pid;
    end
  end

  always_comb begin
    if (clear)                        head_pid_nxt = 1'b0;
    else if (push && wr_q == rd_nxt)  head_pid_nxt = push_pid;
    else                              head_pid_nxt = pid_mem[rd_nxt];
  end
endmodule

// File: rtl/ep_bank_status.sv
module ep_bank_status #(
  parameter int SIZE_W     = 3,
  parameter int MIN_BYTES  = 8,
  parameter int FIFO_BYTES = 256,
  parameter int NBANK_MAX  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ep_dir_in,
  input  logic              ep_iso,
  input  logic              alloc_stb,
  input  logic [SIZE_W-1:0] cfg_size_code,
  input  logic [1:0]        cfg_bank_cnt,
  input  logic              rx_pkt_stb,
  input  logic              rx_pid_data1,
  input  logic              cpu_fill_stb,
  input  logic              bank_release_stb,
  input  logic              in_token_stb,
  input  logic              tx_sent_stb,
  input  logic              tx_ack_stb,
  input  logic              ovf_irq_en,
  input  logic              unf_irq_en,
  input  logic              sw_wr_stb,
  input  logic [7:0]        sw_wr_data,
  output logic [7:0]        status,
  output logic              irq
);
  import ep_status_pkg::*;

  logic [CNT_W-1:0] nb_q, busy_q, busy_nxt;
  logic             cfg_ok_q, chk_ok, in_tog_q, in_tog_nxt, head_pid_nxt;
  logic             ev_ok, push_req, pop_req, has_room, has_data, push_ok, pop_ok;
  logic [FLAG_N-1:0] flg_set, flg_clr, flg_q, flg_nxt;
  ep_stat_t         stat_nxt, stat_q;
  logic             irq_nxt;

  ep_cfg_check #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES),
    .FIFO_BYTES(FIFO_BYTES), .NBANK_MAX(NBANK_MAX)
  ) u_cfg (
    .size_code(cfg_size_code),
    .bank_cnt (cfg_bank_cnt),
    .cfg_ok   (chk_ok)
  );

  // events are dropped in the allocation cycle
  assign ev_ok    = ~alloc_stb;
  assign push_req = ep_dir_in ? cpu_fill_stb : rx_pkt_stb;
  assign pop_req  = ep_dir_in ? (ep_iso ? tx_sent_stb : tx_ack_stb) : bank_release_stb;
  assign has_room = busy_q < nb_q;
  assign has_data = busy_q != '0;
  assign push_ok  = ev_ok & push_req & has_room;
  assign pop_ok   = ev_ok & pop_req & has_data;

  ep_bank_ring #(.NBANK_MAX(NBANK_MAX), .CNT_W(CNT_W)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .clear       (alloc_stb),
    .nb          (nb_q),
    .push        (push_ok),
    .pop         (pop_ok),
    .push_pid    (rx_pid_data1 & ~ep_dir_in),
    .busy_q      (busy_q),
    .busy_nxt    (busy_nxt),
    .head_pid_nxt(head_pid_nxt)
  );

  // index 1 = overflow, index 0 = underflow
  assign flg_set[1] = ev_ok & ~ep_dir_in & ep_iso & rx_pkt_stb & ~has_room;
  assign flg_set[0] = ev_ok &  ep_dir_in & ep_iso & in_token_stb & ~has_data;
  assign flg_clr[1] = sw_wr_stb & ~sw_wr_data[BIT_OVF];
  assign flg_clr[0] = sw_wr_stb & ~sw_wr_data[BIT_UNF];

  for (genvar gf = 0; gf < FLAG_N; gf++) begin : g_flag
    ep_sticky_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .hw_set(flg_set[gf]),
      .sw_clr(flg_clr[gf]),
      .q     (flg_q[gf]),
      .q_nxt (flg_nxt[gf])
    );
  end

  always_comb begin
    if (alloc_stb)                in_tog_nxt = 1'b0;
    else if (ep_dir_in && pop_ok) in_tog_nxt = ~in_tog_q;
    else                          in_tog_nxt = in_tog_q;
  end

  always_comb begin
    stat_nxt.cfg_ok = alloc_stb ? chk_ok : cfg_ok_q;
    stat_nxt.ovf    = flg_nxt[1];
    stat_nxt.unf    = flg_nxt[0];
    stat_nxt.resv   = 1'b0;
    stat_nxt.tog    = {1'b0, ep_dir_in ? in_tog_nxt : head_pid_nxt};
    stat_nxt.busy   = busy_nxt;
    irq_nxt = (flg_nxt[1] & ovf_irq_en) | (flg_nxt[0] & unf_irq_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nb_q     <= '0;
      cfg_ok_q <= 1'b0;
      in_tog_q <= 1'b0;
      stat_q   <= '0;
      irq      <= 1'b0;
    end else begin
      if (alloc_stb) begin
        cfg_ok_q <= chk_ok;
        nb_q     <= chk_ok ? cfg_bank_cnt : '0;
      end
      in_tog_q <= in_tog_nxt;
      stat_q   <= stat_nxt;
      irq      <= irq_nxt;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/ep_bank_status_chk.sv
module ep_bank_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ep_dir_in,
  input logic       ep_iso,
  input logic       alloc_stb,
  input logic       rx_pkt_stb,
  input logic       in_token_stb,
  input logic       sw_wr_stb,
  input logic [7:0] sw_wr_data,
  input logic [7:0] status,
  input logic       irq
);
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !alloc_stb |=> status[7] == $past(status[7]));

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[6]) |-> $past(rx_pkt_stb && ep_iso && !ep_dir_in && !alloc_stb));

  p_unf_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> $past(in_token_stb && ep_iso && ep_dir_in && !alloc_stb));

  p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(status[6]) |-> $past(sw_wr_stb && !sw_wr_data[6]));

  p_unf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(status[5]) |-> $past(sw_wr_stb && !sw_wr_data[5]));

  p_tog_code_r8: assert property (@(posedge clk) disable iff (rst)
    status[3] == 1'b0);

  p_busy_max_r10: assert property (@(posedge clk) disable iff (rst)
    status[1:0] <= 2'd2);

  p_resv_zero_r11: assert property (@(posedge clk) disable iff (rst)
    status[4] == 1'b0);

  p_irq_src_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status[6] || status[5]));
endmodule

bind ep_bank_status ep_bank_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ep_dir_in   (ep_dir_in),
  .ep_iso      (ep_iso),
  .alloc_stb   (alloc_stb),
  .rx_pkt_stb  (rx_pkt_stb),
  .in_token_stb(in_token_stb),
  .sw_wr_stb   (sw_wr_stb),
  .sw_wr_data  (sw_wr_data),
  .status      (status),
  .irq         (irq)
);

// File: tb/ep_bank_status_tb.sv
module ep_bank_status_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ep_dir_in = 0, ep_iso = 0, alloc_stb = 0;
  logic [2:0] cfg_size_code = 0;
  logic [1:0] cfg_bank_cnt = 0;
  logic rx_pkt_stb = 0, rx_pid_data1 = 0, cpu_fill_stb = 0, bank_release_stb = 0;
  logic in_token_stb = 0, tx_sent_stb = 0, tx_ack_stb = 0;
  logic ovf_irq_en = 0, unf_irq_en = 0, sw_wr_stb = 0;
  logic [7:0] sw_wr_data = 0;
  logic [7:0] status;
  logic irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural model state
  bit       m_cfg, m_ovf, m_unf, m_tog, m_rd, m_wr;
  bit [1:0] m_nb, m_busy;
  bit       m_pid [2];
  bit [7:0] exp_stat;
  bit       exp_irq;

  ep_bank_status u_dut (
    .clk(clk), .rst(rst), .ep_dir_in(ep_dir_in), .ep_iso(ep_iso),
    .alloc_stb(alloc_stb), .cfg_size_code(cfg_size_code), .cfg_bank_cnt(cfg_bank_cnt),
    .rx_pkt_stb(rx_pkt_stb), .rx_pid_data1(rx_pid_data1), .cpu_fill_stb(cpu_fill_stb),
    .bank_release_stb(bank_release_stb), .in_token_stb(in_token_stb),
    .tx_sent_stb(tx_sent_stb), .tx_ack_stb(tx_ack_stb), .ovf_irq_en(ovf_irq_en),
    .unf_irq_en(unf_irq_en), .sw_wr_stb(sw_wr_stb), .sw_wr_data(sw_wr_data),
    .status(status), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit cfg_valid(input bit [2:0] code, input bit [1:0] cnt);
    int bytes = 8 * (1 << code);
    return (cnt >= 1) && (cnt <= 2) && (bytes * cnt <= 256);
  endfunction

  function automatic bit [1:0] wrap(input bit [1:0] p, input bit [1:0] n);
    return (p + 2'd1 >= n) ? 2'd0 : p + 2'd1;
  endfunction

  task automatic model_step();
    bit push, pop, set_o, set_u, clr_o, clr_u;
    if (rst) begin
      m_cfg = 0; m_ovf = 0; m_unf = 0; m_tog = 0; m_rd = 0; m_wr = 0;
      m_nb = 0; m_busy = 0; m_pid[0] = 0; m_pid[1] = 0;
      exp_stat = 8'h00; exp_irq = 0;
      return;
    end
    clr_o = sw_wr_stb && !sw_wr_data[6];
    clr_u = sw_wr_stb && !sw_wr_data[5];
    set_o = 0; set_u = 0;
    if (alloc_stb) begin
      m_cfg = cfg_valid(cfg_size_code, cfg_bank_cnt);
      m_nb = m_cfg ? cfg_bank_cnt : 2'd0;
      m_busy = 0; m_rd = 0; m_wr = 0; m_tog = 0; m_pid[0] = 0; m_pid[1] = 0;
    end else begin
      push = (ep_dir_in ? cpu_fill_stb : rx_pkt_stb) && (m_busy < m_nb);
      pop  = (ep_dir_in ? (ep_iso ? tx_sent_stb : tx_ack_stb) : bank_release_stb)
             && (m_busy != 0);
      set_o = !ep_dir_in && ep_iso && rx_pkt_stb && !(m_busy < m_nb);
      set_u = ep_dir_in && ep_iso && in_token_stb && (m_busy == 0);
      if (push && !ep_dir_in) m_pid[m_wr] = rx_pid_data1;
      if (push) m_wr = wrap({1'b0, m_wr}, m_nb) != 0;
      if (pop)  m_rd = wrap({1'b0, m_rd}, m_nb) != 0;
      if (pop && ep_dir_in) m_tog = !m_tog;
      m_busy = m_busy + 2'(push) - 2'(pop);
    end
    m_ovf = set_o || (m_ovf && !clr_o);
    m_unf = set_u || (m_unf && !clr_u);
    exp_stat = {m_cfg, m_ovf, m_unf, 1'b0, 1'b0, ep_dir_in ? m_tog : m_pid[m_rd], m_busy};
    exp_irq = (m_ovf && ovf_irq_en) || (m_unf && unf_irq_en);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic clear_strobes();
    alloc_stb = 0; rx_pkt_stb = 0; cpu_fill_stb = 0; bank_release_stb = 0;
    in_token_stb = 0; tx_sent_stb = 0; tx_ack_stb = 0; sw_wr_stb = 0;
  endtask

  // R13: outputs compared one edge after the strobes
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, {23'd0, status, irq}, {23'd0, exp_stat, exp_irq});
    clear_strobes();
  endtask

  task automatic do_alloc(input bit dir, input bit iso, input bit [2:0] code, input bit [1:0] cnt);
    ep_dir_in = dir; ep_iso = iso; cfg_size_code = code; cfg_bank_cnt = cnt;
    alloc_stb = 1;
    tick("R2 alloc");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1 reset
    rst = 1;
    tick("R1 reset");
    tick("R1 reset");
    chk("R1 status zero", {24'd0, status}, 32'h0);
    rst = 0;

    // R2 configuration checks
    do_alloc(0, 1, 3'd5, 2'd1); chk("R2 256x1 ok", status[7], 1);
    do_alloc(0, 1, 3'd5, 2'd2); chk("R2 256x2 fail", status[7], 0);
    do_alloc(0, 1, 3'd6, 2'd1); chk("R2 512x1 fail", status[7], 0);
    do_alloc(0, 1, 3'd0, 2'd3); chk("R2 three banks fail", status[7], 0);
    do_alloc(0, 1, 3'd0, 2'd0); chk("R2 zero banks fail", status[7], 0);
    do_alloc(0, 1, 3'd4, 2'd2); chk("R2 128x2 ok", status[7], 1);

    // OUT iso: fill both banks, then overflow
    rx_pkt_stb = 1; rx_pid_data1 = 1; tick("R10 rx0");
    rx_pkt_stb = 1; rx_pid_data1 = 0; tick("R10 rx1");
    chk("R10 busy two", status[1:0], 2);
    chk("R8 head DATA1", status[3:2], 2'b01);
    rx_pkt_stb = 1; tick("R4 rx full");
    chk("R4 overflow set", status[6], 1);
    chk("R10 busy saturates", status[1:0], 2);
    bank_release_stb = 1; tick("R8 release");
    chk("R8 head DATA0", status[3:2], 2'b00);
    ovf_irq_en = 1; tick("R12 enable");
    chk("R12 irq high", irq, 1);

    // R6 / R11 software writes
    sw_wr_stb = 1; sw_wr_data = 8'hFF; tick("R6 write ones");
    chk("R6 one no effect", status[6], 1);
    chk("R11 reserved zero", status[4], 0);
    sw_wr_stb = 1; sw_wr_data = 8'hBF; tick("R6 clear");
    chk("R6 cleared", status[6], 0);
    chk("R12 irq low", irq, 0);

    // R7 set beats clear (one free bank, fill then overflow with clear)
    rx_pkt_stb = 1; tick("R7 fill");
    rx_pkt_stb = 1; sw_wr_stb = 1; sw_wr_data = 8'h00; tick("R7 race");
    chk("R7 set wins", status[6], 1);
    sw_wr_stb = 1; sw_wr_data = 8'h00; tick("R6 clear all");

    // IN iso: underflow and toggle
    unf_irq_en = 1;
    do_alloc(1, 1, 3'd3, 2'd2);
    in_token_stb = 1; tick("R5 token empty");
    chk("R5 underflow", status[5], 1);
    chk("R12 irq unf", irq, 1);
    cpu_fill_stb = 1; tick("R10 fill");
    cpu_fill_stb = 1; tick("R10 fill");
    cpu_fill_stb = 1; tick("R10 fill full");
    chk("R10 fill ignored", status[1:0], 2);
    tx_sent_stb = 1; tick("R9 iso sent");
    chk("R9 iso toggle", status[3:2], 2'b01);
    sw_wr_stb = 1; sw_wr_data = 8'h00; tick("R6 clear unf");

    // IN non-iso: sent alone does nothing, ack flips
    do_alloc(1, 0, 3'd2, 2'd1);
    cpu_fill_stb = 1; tick("R10 fill");
    tx_sent_stb = 1; tick("R9 sent no ack");
    chk("R9 no flip on sent", status[3:0], 4'b0001);
    tx_ack_stb = 1; tick("R9 ack");
    chk("R9 flip on ack", status[3:0], 4'b0100);

    // Random traffic in each mode
    for (int mode = 0; mode < 4; mode++) begin
      bit [2:0] code = 3'($urandom_range(0, 5));
      bit [1:0] cnt = 2'($urandom_range(1, 2));
      ovf_irq_en = 1'($urandom); unf_irq_en = 1'($urandom);
      do_alloc(mode[0], mode[1], code, cnt);
      for (int i = 0; i < 500; i++) begin
        rx_pkt_stb = ($urandom_range(0, 3) == 0);
        rx_pid_data1 = 1'($urandom);
        cpu_fill_stb = ($urandom_range(0, 3) == 0);
        bank_release_stb = ($urandom_range(0, 3) == 0);
        in_token_stb = ($urandom_range(0, 3) == 0);
        tx_sent_stb = ($urandom_range(0, 3) == 0);
        tx_ack_stb = ($urandom_range(0, 4) == 0);
        sw_wr_stb = ($urandom_range(0, 15) == 0);
        sw_wr_data = 8'($urandom);
        if ($urandom_range(0, 99) == 0) ovf_irq_en = ~ovf_irq_en;
        if ($urandom_range(0, 199) == 0) begin
          cfg_size_code = 3'($urandom); cfg_bank_cnt = 2'($urandom); alloc_stb = 1;
        end
        tick("R3 R4 R5 R8 R9 R10 R12 random");
      end
    end

    // R1 reset after traffic
    rst = 1; tick("R1 late reset"); rst = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule